// File: doc/BRIEF.md
# Task Register Load Checker

This block decides whether a load of the task register may proceed. The selector and the descriptor it names have already been fetched from the descriptor table by the time a request arrives; the block looks at the selector's index, its table bit, a flag telling whether selector parsing failed, and the descriptor's system bit, type code, present bit, base and limit. It reports one of two outcomes.

The first outcome is a fault. The fault can be general-protection, invalid task state, or segment not present, and it carries the selector index as its error code. The second outcome is a commit. On a commit the task register takes the descriptor with its type changed to the busy form. For a 32-bit task state, the commit also issues a read request for the halfword that holds the I/O permission map base.

The checks run in a fixed priority. Selector and system-bit problems are found first. Next come the type and the minimum limit for the type. The present bit is checked last. Walking the descriptor table and writing the busy bit back to memory belong to other blocks.

Top module: `task_reg_loader`

## Requirements
- R1: A request whose parse-error flag is set, whose selector table bit selects the local table, or whose descriptor system bit is 0 raises a general-protection fault. This takes priority over every other check. The fault class encodings on `faultClass` are: 1 for general-protection, 2 for invalid task state, 3 for not present. `faultCode` carries the selector index.
- R2: Descriptor type 4'h1 is an available 16-bit task state. It raises an invalid-task-state fault when the limit is below 0x2B. A limit of exactly 0x2B passes.
- R3: Descriptor type 4'h9 is an available 32-bit task state. It raises an invalid-task-state fault when the limit is below 0x67. A limit of exactly 0x67 passes.
- R4: Every other type code raises a general-protection fault. This includes the busy codes 4'h3 and 4'hB and the local-table code 4'h2.
- R5: A descriptor that passes the type and limit checks but has its present bit at 0 raises a not-present fault. If the limit is too small and the descriptor is also absent, the fault is invalid task state.
- R6: A request that passes all checks produces a commit. `trIndex`, `trBase` and `trLimit` take the selector index and the descriptor base and limit. `trType` takes the type with bit 1 set, so 4'h1 becomes 4'h3 and 4'h9 becomes 4'hB.
- R7: A 32-bit commit asserts `ioReadValid` in the same cycle as the commit, with `ioReadAddr` equal to the descriptor base plus 102 (decimal). A 16-bit commit issues no read, because its map base is taken as 0.
- R8: The outcome appears in the cycle after the request is sampled. `faultValid` and `commitValid` each pulse for one cycle per request and are never high together. With no request, neither output asserts.
- R9: A fault leaves the task register outputs (`trIndex`, `trType`, `trBase`, `trLimit`) unchanged.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; the fields below are sampled when it is high |
| selIndex | input | IDX_W (13) | Selector index |
| selLocal | input | 1 | Selector table bit; 1 selects the local table |
| selParseErr | input | 1 | Selector parsing failed upstream |
| descSystem | input | 1 | Descriptor system bit; 1 means a system descriptor |
| descType | input | 4 | Descriptor type code |
| descPresent | input | 1 | Descriptor present bit |
| descBase | input | ADDR_W (32) | Descriptor base address |
| descLimit | input | LIM_W (32) | Descriptor limit in bytes |
| faultValid | output | 1 | One-cycle fault pulse |
| faultClass | output | 2 | Fault class: 1 general-protection, 2 invalid task state, 3 not present |
| faultCode | output | IDX_W (13) | Error code, equal to the selector index |
| commitValid | output | 1 | One-cycle commit pulse |
| trIndex | output | IDX_W (13) | Task register selector index |
| trType | output | 4 | Task register descriptor type (busy form) |
| trBase | output | ADDR_W (32) | Task register base |
| trLimit | output | LIM_W (32) | Task register limit |
| ioReadValid | output | 1 | One-cycle read request for the I/O map base halfword |
| ioReadAddr | output | ADDR_W (32) | Address of that read |

## Verification
The assertions assume that the request fields are stable and known whenever `reqValid` is high, and that `reqValid` stays low during reset. Several assertions compare a registered result against the request fields through `$past`, which is why these assumptions matter. The bench changes inputs only on falling edges and holds `reqValid` low through reset. It drives known values on every field of every request, including the fields that a higher-priority check makes irrelevant. Requests are sent both back to back and separated by idle cycles, so the one-cycle pulse property is tested in both patterns.

// File: rtl/trlv_pkg.sv
package trlv_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_GP   = 2'd1,
    FC_TS   = 2'd2,
    FC_NP   = 2'd3
  } faultClass_e;

  localparam logic [3:0] TYPE_AVAIL16 = 4'h1;
  localparam logic [3:0] TYPE_AVAIL32 = 4'h9;
  localparam logic [3:0] TYPE_BUSY32  = 4'hB;
  localparam int unsigned BUSY_BIT    = 1;

  typedef struct packed {
    logic loadTr;
    logic raiseFault;
    logic is32;
  } trlvStrobes_t;

endpackage

// File: rtl/trlv_ctrl.sv
module trlv_ctrl
  import trlv_pkg::*;
#(
  parameter int unsigned LIM_W   = 32,
  parameter int unsigned MIN16   = 'h2B,
  parameter int unsigned MIN32   = 'h67
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             selLocal,
  input  logic             selParseErr,
  input  logic             descSystem,
  input  logic [3:0]       descType,
  input  logic             descPresent,
  input  logic [LIM_W-1:0] descLimit,
  output trlvStrobes_t     strb,
  output logic             faultValid,
  output faultClass_e      faultClass,
  output logic             commitValid
);

  localparam logic [LIM_W-1:0] MIN16_L = LIM_W'(MIN16);
  localparam logic [LIM_W-1:0] MIN32_L = LIM_W'(MIN32);

  faultClass_e nextClass;
  logic        nextCommit;
  logic        selBad;
  logic        limitShort;

  assign selBad = selParseErr | selLocal | ~descSystem;

  always_comb begin
    limitShort = 1'b0;
    if (descType == TYPE_AVAIL16)      limitShort = descLimit < MIN16_L;
    else if (descType == TYPE_AVAIL32) limitShort = descLimit < MIN32_L;
  end

  // Priority: selector/system -> type -> limit -> present
  always_comb begin
    nextClass  = FC_NONE;
    nextCommit = 1'b0;
    if (reqValid) begin
      if (selBad) begin
        nextClass = FC_GP;
      end else if (descType != TYPE_AVAIL16 && descType != TYPE_AVAIL32) begin
        nextClass = FC_GP;
      end else if (limitShort) begin
        nextClass = FC_TS;
      end else if (!descPresent) begin
        nextClass = FC_NP;
      end else begin
        nextCommit = 1'b1;
      end
    end
  end

  always_comb begin
    strb.loadTr     = nextCommit;
    strb.raiseFault = (nextClass != FC_NONE);
    strb.is32       = (descType == TYPE_AVAIL32);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faultValid  <= 1'b0;
      faultClass  <= FC_NONE;
      commitValid <= 1'b0;
    end else begin
      faultValid  <= (nextClass != FC_NONE);
      faultClass  <= nextClass;
      commitValid <= nextCommit;
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(faultValid && commitValid));

  a_r8_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (faultValid || commitValid) |-> $past(reqValid));

  a_r1_selector_gp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reqValid && (selParseErr || selLocal)) |-> (faultValid && faultClass == FC_GP));

  a_r2_r3_short_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (faultValid && faultClass == FC_TS) |->
      ($past(descType) == TYPE_AVAIL16 ? ($past(descLimit) < MIN16_L)
                                       : ($past(descLimit) < MIN32_L)));

  a_r5_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (faultValid && faultClass == FC_NP) |-> !$past(descPresent));

endmodule

// File: rtl/trlv_datapath.sv
module trlv_datapath
  import trlv_pkg::*;
#(
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LIM_W     = 32,
  parameter int unsigned IOMAP_OFS = 102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trlvStrobes_t      strb,
  input  logic [IDX_W-1:0]  selIndex,
  input  logic [3:0]        descType,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [LIM_W-1:0]  descLimit,
  output logic [IDX_W-1:0]  faultCode,
  output logic [IDX_W-1:0]  trIndex,
  output logic [3:0]        trType,
  output logic [ADDR_W-1:0] trBase,
  output logic [LIM_W-1:0]  trLimit,
  output logic              ioReadValid,
  output logic [ADDR_W-1:0] ioReadAddr
);

  localparam logic [ADDR_W-1:0] IOMAP_OFS_A = ADDR_W'(IOMAP_OFS);

  logic [3:0] busyType;
  always_comb begin
    busyType           = descType;
    busyType[BUSY_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faultCode   <= '0;
      trIndex     <= '0;
      trType      <= '0;
      trBase      <= '0;
      trLimit     <= '0;
      ioReadValid <= 1'b0;
      ioReadAddr  <= '0;
    end else begin
      ioReadValid <= strb.loadTr & strb.is32;
      if (strb.raiseFault) faultCode <= selIndex;
      if (strb.loadTr) begin
        trIndex <= selIndex;
        trType  <= busyType;
        trBase  <= descBase;
        trLimit <= descLimit;
        if (strb.is32) ioReadAddr <= descBase + IOMAP_OFS_A;
      end
    end
  end

  a_r6_busy_form: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.loadTr) |-> trType[BUSY_BIT]);

  a_r7_read_only_32: assert property (@(posedge clk) disable iff (!rst_n)
    ioReadValid |-> (trType == TYPE_BUSY32));

  a_r9_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.raiseFault) |-> ($stable(trIndex) && $stable(trBase) && $stable(trLimit)
                                && $stable(trType)));

endmodule

// File: rtl/task_reg_loader.sv
module task_reg_loader
  import trlv_pkg::*;
#(
  parameter int unsigned IDX_W  = 13,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  selIndex,
  input  logic              selLocal,
  input  logic              selParseErr,
  input  logic              descSystem,
  input  logic [3:0]        descType,
  input  logic              descPresent,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [LIM_W-1:0]  descLimit,
  output logic              faultValid,
  output logic [1:0]        faultClass,
  output logic [IDX_W-1:0]  faultCode,
  output logic              commitValid,
  output logic [IDX_W-1:0]  trIndex,
  output logic [3:0]        trType,
  output logic [ADDR_W-1:0] trBase,
  output logic [LIM_W-1:0]  trLimit,
  output logic              ioReadValid,
  output logic [ADDR_W-1:0] ioReadAddr
);

  trlvStrobes_t strb;
  faultClass_e  faultClassE;

  trlv_ctrl #(.LIM_W(LIM_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .selLocal    (selLocal),
    .selParseErr (selParseErr),
    .descSystem  (descSystem),
    .descType    (descType),
    .descPresent (descPresent),
    .descLimit   (descLimit),
    .strb        (strb),
    .faultValid  (faultValid),
    .faultClass  (faultClassE),
    .commitValid (commitValid)
  );

  assign faultClass = faultClassE;

  trlv_datapath #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .selIndex    (selIndex),
    .descType    (descType),
    .descBase    (descBase),
    .descLimit   (descLimit),
    .faultCode   (faultCode),
    .trIndex     (trIndex),
    .trType      (trType),
    .trBase      (trBase),
    .trLimit     (trLimit),
    .ioReadValid (ioReadValid),
    .ioReadAddr  (ioReadAddr)
  );

endmodule

// File: tb/task_reg_loader_bench.sv
module task_reg_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [12:0] selIndex = '0;
  logic        selLocal = 1'b0;
  logic        selParseErr = 1'b0;
  logic        descSystem = 1'b0;
  logic [3:0]  descType = '0;
  logic        descPresent = 1'b0;
  logic [31:0] descBase = '0;
  logic [31:0] descLimit = '0;
  logic        faultValid;
  logic [1:0]  faultClass;
  logic [12:0] faultCode;
  logic        commitValid;
  logic [12:0] trIndex;
  logic [3:0]  trType;
  logic [31:0] trBase;
  logic [31:0] trLimit;
  logic        ioReadValid;
  logic [31:0] ioReadAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_reg_loader u_task_reg_loader (
    .clk, .rst_n, .reqValid, .selIndex, .selLocal, .selParseErr, .descSystem,
    .descType, .descPresent, .descBase, .descLimit, .faultValid, .faultClass,
    .faultCode, .commitValid, .trIndex, .trType, .trBase, .trLimit,
    .ioReadValid, .ioReadAddr
  );

  typedef struct {
    bit          isFault;
    logic [1:0]  cls;
    logic [12:0] code;
    logic [12:0] tIdx;
    logic [3:0]  tType;
    logic [31:0] tBase;
    logic [31:0] tLim;
    bit          ioRd;
    logic [31:0] ioAddr;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model of the task register
  logic [12:0] mIdx = '0;
  logic [3:0]  mType = '0;
  logic [31:0] mBase = '0;
  logic [31:0] mLim = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sendReq(input logic [12:0] idx, input bit loc, input bit perr,
                         input bit sys, input logic [3:0] typ, input bit pres,
                         input logic [31:0] base, input logic [31:0] lim,
                         input string tag);
    expItem_t e;
    @(negedge clk);
    selIndex = idx; selLocal = loc; selParseErr = perr; descSystem = sys;
    descType = typ; descPresent = pres; descBase = base; descLimit = lim;
    reqValid = 1'b1;
    e.tag = tag; e.code = idx; e.isFault = 1'b1; e.cls = 2'd0; e.ioRd = 1'b0;
    e.ioAddr = 32'h0;
    if (perr || loc || !sys) e.cls = 2'd1;
    else if (typ != 4'h1 && typ != 4'h9) e.cls = 2'd1;
    else if (typ == 4'h1 && lim < 32'h2B) e.cls = 2'd2;
    else if (typ == 4'h9 && lim < 32'h67) e.cls = 2'd2;
    else if (!pres) e.cls = 2'd3;
    else begin
      e.isFault = 1'b0;
      mIdx = idx; mType = typ | 4'h2; mBase = base; mLim = lim;
      if (typ == 4'h9) begin
        e.ioRd = 1'b1;
        e.ioAddr = base + 32'd102;
      end
    end
    e.tIdx = mIdx; e.tType = mType; e.tBase = mBase; e.tLim = mLim;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor: scoreboard compare after each rising edge
  initial begin
    expItem_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        chk("R8", "faultValid", 32'(faultValid), 32'(e.isFault));
        chk("R8", "commitValid", 32'(commitValid), 32'(!e.isFault));
        if (e.isFault) begin
          chk(e.tag, "faultClass", 32'(faultClass), 32'(e.cls));
          chk(e.tag, "faultCode", 32'(faultCode), 32'(e.code));
          chk("R9", "trIndex", 32'(trIndex), 32'(e.tIdx));
          chk("R9", "trBase", trBase, e.tBase);
        end else begin
          chk(e.tag, "trIndex", 32'(trIndex), 32'(e.tIdx));
          chk("R6", "trType", 32'(trType), 32'(e.tType));
          chk(e.tag, "trBase", trBase, e.tBase);
          chk(e.tag, "trLimit", trLimit, e.tLim);
        end
        chk("R7", "ioReadValid", 32'(ioReadValid), 32'(e.ioRd));
        if (e.ioRd) chk("R7", "ioReadAddr", ioReadAddr, e.ioAddr);
      end else begin
        chk("R8", "idle outputs", {29'h0, faultValid, commitValid, ioReadValid}, 32'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "outputs in reset",
        {29'h0, faultValid, commitValid, ioReadValid}, 32'h0);
    chk("R10", "trIndex", 32'(trIndex), 32'h0);
    chk("R10", "trBase", trBase, 32'h0);
    chk("R10", "faultClass", 32'(faultClass), 32'h0);
    rst_n = 1'b1;
    idle(2);
    // R3 boundary pass, R7 read
    sendReq(13'h0041, 0, 0, 1, 4'h9, 1, 32'h0010_0000, 32'h67, "R3");
    idle(1);
    // R2 boundary pass, no read
    sendReq(13'h0102, 0, 0, 1, 4'h1, 1, 32'h0002_0400, 32'h2B, "R2");
    idle(1);
    sendReq(13'h0033, 0, 0, 1, 4'h9, 1, 32'h0030_0000, 32'h66, "R3");
    sendReq(13'h0034, 0, 0, 1, 4'h1, 1, 32'h0040_0000, 32'h2A, "R2");
    // R1 priority: parse error with absent, bad type
    sendReq(13'h1FFF, 0, 1, 1, 4'h5, 0, 32'h0, 32'h0, "R1");
    sendReq(13'h0007, 1, 0, 1, 4'h9, 1, 32'h0050_0000, 32'hFFF, "R1");
    sendReq(13'h0008, 0, 0, 0, 4'h9, 1, 32'h0060_0000, 32'hFFF, "R1");
    // R4 other types
    sendReq(13'h0009, 0, 0, 1, 4'hB, 1, 32'h0070_0000, 32'hFFF, "R4");
    sendReq(13'h000A, 0, 0, 1, 4'h3, 1, 32'h0070_0000, 32'hFFF, "R4");
    sendReq(13'h000B, 0, 0, 1, 4'h2, 1, 32'h0070_0000, 32'hFFF, "R4");
    // R5 absent after limit ok; short limit beats absent
    sendReq(13'h000C, 0, 0, 1, 4'h9, 0, 32'h0080_0000, 32'h68, "R5");
    sendReq(13'h000D, 0, 0, 1, 4'h1, 0, 32'h0080_0000, 32'h10, "R5");
    idle(2);
    // back-to-back commits then a fault: R8, R9
    sendReq(13'h0ABC, 0, 0, 1, 4'h1, 1, 32'hFFFF_FF00, 32'h1000, "R6");
    sendReq(13'h0ABD, 0, 0, 1, 4'h9, 1, 32'hFFFF_FFC0, 32'hFFFF_FFFF, "R7");
    sendReq(13'h0ABE, 0, 0, 1, 4'h9, 0, 32'h1234_0000, 32'h2000, "R9");
    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule